// File: doc/BRIEF.md
# Bidirectional Port with Pin Pull-ups

This block is a byte-wide general-purpose I/O port. A direction register picks input or output mode for each pin. A data register holds the driven value for output pins. On input pins the same data register bit switches on a weak pull-up instead. A narrow register bus writes both registers. Reading the data address returns a port view that mixes two sources: the live, synchronized level for each input pin and the stored data bit for each output pin. Reading the direction address always returns all ones.

A single-bit command sets or clears one bit by read-modify-write. The command takes the mixed port view, changes the chosen bit, and writes the whole byte back to the data register. As a result, input pins whose level differs from their stored bit have their pull-up state changed by the command. This side effect is reproduced on purpose. While a command runs, a busy output is high for two cycles, and no bus write or new command is accepted.

Top module: `gpio_port_pu`

## Requirements
- R1: After reset every pin is an input (`pin_oe` = 0x00), `pin_out` = 0x00, `pin_pu` = 0x00 and `busy` = 0.
- R2: A bus write (`bus_req`=1, `bus_wr`=1) to address 1 loads the direction register. Bit value 1 makes the pin an output and appears on `pin_oe` after the clock edge.
- R3: A bus write to address 0 loads the data register. `pin_out` carries the data bit on output pins and 0 on input pins.
- R4: `pin_pu` equals the data bit on input pins and is 0 on every output pin.
- R5: A read at address 0 returns the synchronized pin level for input bits and the data bit for output bits. A read at address 1 returns 0xFF.
- R6: A pin level reaches the port view through a two-flop synchronizer. A change applied between two edges is not visible after the first rising edge and is visible after the second.
- R7: A set command (`bop_req`=1, `bop_set`=1, `bop_idx`=n) writes the mixed port view with bit n forced to 1 into the data register. Example: data 0x80, direction 0x3F, pin7 low and pin6 high; setting bit 0 stores 0x41, pin0 drives high, pin7's pull-up turns off and pin6's pull-up turns on.
- R8: A clear command (`bop_set`=0) does the same with bit n forced to 0.
- R9: `busy` rises after the edge that accepts a command and stays high for exactly two cycles. The data register changes only at the edge that ends the second cycle.
- R10: While `busy` is high, bus writes and new commands are ignored. When a command and a bus write arrive in the same cycle, the command is taken and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data/port, 1 = direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| bop_req | input | 1 | Single-bit command request |
| bop_set | input | 1 | 1 = set bit, 0 = clear bit |
| bop_idx | input | 3 | Bit index for the command |
| busy | output | 1 | Command in progress |
| pin_in | input | 8 | External pin levels |
| pin_oe | output | 8 | Output enable per pin |
| pin_out | output | 8 | Driven value per pin |
| pin_pu | output | 8 | Pull-up enable per pin |

## Verification
The main target is the mixed-read corner case. There, a set command on an output bit must rewrite the data bits of the input pins from their pin levels. A design that modified the stored register instead of the port view would leave both pull-ups unchanged. A clear command on a port with high input pins checks the same path in the other polarity.

Synchronizer latency is checked one edge at a time, so a one-flop or three-flop version is caught. The hold-off cases send a direction write together with a command, and another write plus a second command during the busy window. A design that let either through would show changed enables or a different stored byte.

// File: rtl/gpio_pu_pkg.sv
package gpio_pu_pkg;

  typedef enum logic [1:0] {
    RMW_IDLE  = 2'd0,
    RMW_READ  = 2'd1,
    RMW_WRITE = 2'd2
  } rmw_state_e;

  localparam logic ADDR_PORT = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            chain_q[0] <= '0;
          end else begin
            chain_q[0] <= async_in;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            chain_q[s] <= '0;
          end else begin
            chain_q[s] <= chain_q[s-1];
          end
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic [WIDTH-1:0] dir_wdata,
  input  logic             dat_we,
  input  logic [WIDTH-1:0] dat_wdata,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] port_view,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_pu
);

  logic [WIDTH-1:0] dir_q, dir_d;
  logic [WIDTH-1:0] dat_q, dat_d;

  // next-state with explicit enables
  always_comb begin
    dir_d = dir_q;
    dat_d = dat_q;
    if (dir_we) dir_d = dir_wdata;
    if (dat_we) dat_d = dat_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
    end else begin
      dir_q <= dir_d;
      dat_q <= dat_d;
    end
  end

  // per-pin pad control and read mux
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign pin_oe[b]    = dir_q[b];
      assign pin_out[b]   = dir_q[b] & dat_q[b];
      assign pin_pu[b]    = ~dir_q[b] & dat_q[b];
      assign port_view[b] = dir_q[b] ? dat_q[b] : pin_sync[b];
    end
  endgenerate

endmodule

// File: rtl/gpio_rmw_ctrl.sv
module gpio_rmw_ctrl
  import gpio_pu_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             set_op,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] port_view,
  output logic             busy,
  output logic             dat_we,
  output logic [WIDTH-1:0] dat_wdata
);

  rmw_state_e       state_q, state_d;
  logic             op_q, op_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WIDTH-1:0] snap_q, snap_d;
  logic [WIDTH-1:0] modified;

  always_comb begin
    modified = port_view;
    modified[idx_q] = op_q;
  end

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    idx_d   = idx_q;
    snap_d  = snap_q;
    case (state_q)
      RMW_IDLE: begin
        if (start) begin
          state_d = RMW_READ;
          op_d    = set_op;
          idx_d   = idx;
        end
      end
      RMW_READ: begin
        snap_d  = modified;
        state_d = RMW_WRITE;
      end
      RMW_WRITE: begin
        state_d = RMW_IDLE;
      end
      default: state_d = RMW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RMW_IDLE;
      op_q    <= 1'b0;
      idx_q   <= '0;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      idx_q   <= idx_d;
      snap_q  <= snap_d;
    end
  end

  assign busy      = (state_q != RMW_IDLE);
  assign dat_we    = (state_q == RMW_WRITE);
  assign dat_wdata = snap_q;

endmodule

// File: rtl/gpio_port_pu.sv
module gpio_port_pu
  import gpio_pu_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_req,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             bop_req,
  input  logic             bop_set,
  input  logic [IDX_W-1:0] bop_idx,
  output logic             busy,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_pu
);

  logic             rst_sync_n;
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] port_view;
  logic             rmw_we;
  logic [WIDTH-1:0] rmw_wdata;
  logic             bop_take;
  logic             bus_take;
  logic             dir_we;
  logic             dat_we;
  logic [WIDTH-1:0] dat_wdata;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  // command wins over a same-cycle bus write; nothing accepted while busy
  assign bop_take  = bop_req & ~busy;
  assign bus_take  = bus_req & bus_wr & ~busy & ~bop_req;
  assign dir_we    = bus_take & (bus_addr == ADDR_DIR);
  assign dat_we    = rmw_we | (bus_take & (bus_addr == ADDR_PORT));
  assign dat_wdata = rmw_we ? rmw_wdata : bus_wdata;

  gpio_rmw_ctrl #(.WIDTH(WIDTH)) u_rmw (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (bop_take),
    .set_op    (bop_set),
    .idx       (bop_idx),
    .port_view (port_view),
    .busy      (busy),
    .dat_we    (rmw_we),
    .dat_wdata (rmw_wdata)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dir_we    (dir_we),
    .dir_wdata (bus_wdata),
    .dat_we    (dat_we),
    .dat_wdata (dat_wdata),
    .pin_sync  (pin_sync),
    .port_view (port_view),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_pu    (pin_pu)
  );

  assign bus_rdata = (bus_addr == ADDR_DIR) ? {WIDTH{1'b1}} : port_view;

endmodule

// File: rtl/gpio_port_pu_chk.sv
module gpio_port_pu_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             bus_addr,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_pu
);

  a_r4_pu_off_on_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0);

  a_r3_no_drive_on_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  a_r5_dir_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr |-> (bus_rdata == {WIDTH{1'b1}}));

  a_r9_busy_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (busy ##1 !busy));

  a_r9_no_write_in_read_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> ($stable(pin_out) && $stable(pin_pu)));

  a_r10_dir_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pin_oe));

endmodule

bind gpio_port_pu gpio_port_pu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy      (busy),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .pin_pu    (pin_pu)
);

// File: tb/gpio_port_pu_bench.sv
`timescale 1ns/1ps
module gpio_port_pu_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_req, bus_wr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       bop_req, bop_set;
  logic [2:0] bop_idx;
  logic       busy;
  logic [7:0] pin_in, pin_oe, pin_out, pin_pu;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_port_pu u_gpio_port_pu (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bop_req(bop_req), .bop_set(bop_set), .bop_idx(bop_idx), .busy(busy),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // runs one command; checks busy on each cycle (R9)
  task automatic bit_op(input logic s, input logic [2:0] n, input logic [7:0] out_before);
    @(negedge clk);
    bop_req = 1'b1; bop_set = s; bop_idx = n;
    @(negedge clk);
    bop_req = 1'b0;
    chk("R9 busy after accept", {7'b0, busy}, 8'h01);
    @(negedge clk);
    chk("R9 busy in second cycle", {7'b0, busy}, 8'h01);
    chk("R9 data unchanged before write", pin_out, out_before);
    @(negedge clk);
    chk("R9 busy drops", {7'b0, busy}, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] r;
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pin_pu", pin_pu, 8'h00);
    chk("R1 busy", {7'b0, busy}, 8'h00);
    bus_read(1'b1, r);
    chk("R5 dir read", r, 8'hFF);
  endtask

  task automatic t_regs;
    logic [7:0] r;
    pin_in = 8'h00;
    bus_write(1'b1, 8'h0F);
    bus_write(1'b0, 8'h3C);
    chk("R2 pin_oe", pin_oe, 8'h0F);
    chk("R3 pin_out", pin_out, 8'h0C);
    chk("R4 pin_pu", pin_pu, 8'h30);
    idle(3);
    bus_read(1'b0, r);
    chk("R5 mixed read pins low", r, 8'h0C);
    pin_in = 8'hA5;
    idle(3);
    bus_read(1'b0, r);
    chk("R5 mixed read pins A5", r, 8'hAC);
  endtask

  task automatic t_sync;
    logic [7:0] r;
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h00);
    pin_in = 8'h00;
    idle(3);
    pin_in = 8'h5A;
    @(negedge clk);
    bus_read(1'b0, r);
    chk("R6 not visible after one edge", r, 8'h00);
    @(negedge clk);
    bus_read(1'b0, r);
    chk("R6 visible after two edges", r, 8'h5A);
  endtask

  task automatic t_set_corner;
    logic [7:0] r;
    bus_write(1'b1, 8'h3F);
    bus_write(1'b0, 8'h80);
    pin_in = 8'h40;
    idle(3);
    chk("R7 pull-up before", pin_pu, 8'h80);
    bit_op(1'b1, 3'd0, 8'h00);
    chk("R7 pin0 drives high", pin_out, 8'h01);
    chk("R7 pull-ups swapped", pin_pu, 8'h40);
    bus_read(1'b0, r);
    chk("R7 port view", r, 8'h41);
  endtask

  task automatic t_clear;
    bus_write(1'b1, 8'h0F);
    bus_write(1'b0, 8'h0F);
    pin_in = 8'hA0;
    idle(3);
    bit_op(1'b0, 3'd2, 8'h0F);
    chk("R8 pin_out", pin_out, 8'h0B);
    chk("R8 pin_pu from pin levels", pin_pu, 8'hA0);
  endtask

  task automatic t_holdoff;
    logic [7:0] r;
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'h00);
    pin_in = 8'h00;
    idle(3);
    @(negedge clk);
    bop_req = 1'b1; bop_set = 1'b1; bop_idx = 3'd3;
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'hFF;
    @(negedge clk);
    bop_set = 1'b0; bop_idx = 3'd7;
    bus_addr = 1'b0; bus_wdata = 8'hFF;
    @(negedge clk);
    bop_req = 1'b0; bus_req = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
    chk("R10 direction write dropped", pin_oe, 8'h00);
    chk("R10 only first command applied", pin_pu, 8'h08);
    bus_read(1'b0, r);
    chk("R10 port view", r, 8'h00);
    chk("R10 no second command", {7'b0, busy}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_req = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
    bop_req = 1'b0; bop_set = 1'b0; bop_idx = 3'd0;
    pin_in = 8'h00;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regs();
    t_sync();
    t_set_corner();
    t_clear();
    t_holdoff();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule